// File: doc/BRIEF.md
# Handshake Word Transfer Between Clock Domains

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. The word itself never passes through a synchronizer. The source side latches the word into a holding register and keeps it unchanged. It then moves a single request line. The destination synchronizes that line, detects the event, and samples the holding register, which has been stable for several of its own cycles by then. Its reply is a single acknowledge line that travels back through a synchronizer in the source domain.

A build parameter selects the signalling scheme. In return-to-zero mode, request and acknowledge both rise and then both fall for every word. In toggle mode, each change of the request level, up or down, carries one word. The acknowledge then follows by matching that level. The source side offers a valid/ready acceptance pair. The destination side produces a one-cycle valid strobe with the captured word. Each domain has its own clock and its own active-low reset.

Top module: `hs_bus_xfer`

## Requirements
- R1: After reset, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0. The request and acknowledge lines are 0 in both domains.
- R2: Every word accepted on a source cycle with `src_valid` and `src_ready` both 1 appears exactly once on `dst_data`, in acceptance order, during a cycle with `dst_valid` at 1.
- R3: `src_ready` is 0 from the cycle after an acceptance until the handshake for that word has fully completed. While it is 0, `src_valid` is ignored and produces no delivery.
- R4: `dst_valid` is never high on two consecutive destination cycles. `dst_data` changes only on a cycle where `dst_valid` is 1.
- R5: Changes on `src_data` after acceptance have no effect on the delivered word. The held word stays constant until the source reaches idle again.
- R6: With `TWO_PHASE`=0, the order for each word is: request rises, acknowledge rises, request falls, acknowledge falls. `src_ready` returns only after the synchronized acknowledge has fallen. One word occupies the source for at least 4×`SYNC_STAGES` source cycles.
- R7: With `TWO_PHASE`=1, each change of the request level carries one word, rising and falling alike. The acknowledge toggles once per capture. The source is free again once the synchronized acknowledge equals the request level. The total source busy time is shorter than in return-to-zero mode.
- R8: Request and acknowledge each pass through `SYNC_STAGES` flip-flops (at least 2) in the receiving domain, with no logic before the first one. The destination samples the held word on the cycle after it detects the synchronized event. The time from the accepting source edge to the rise of `dst_valid` therefore exceeds (`SYNC_STAGES`+1) destination periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source side can accept a word |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_valid | output | 1 | One-cycle strobe: a new word is on dst_data |
| dst_data | output | DATA_W | Last captured word |

## Verification
The hardest case to reach from the ports is a source that keeps asserting `src_valid` and changing `src_data` while a handshake is in flight. This has to happen across the whole uneven spread of relative clock phases between the two domains. The bench drives random valid and data noise on every busy source cycle. It uses clock periods whose edges never coincide and slide against each other over the run. It then checks that only the accepted words arrive, intact and in order. A second instance in toggle mode with a deeper synchronizer sends an even number of words, so that requests carried by both a rising and a falling level change are captured and checked.

// File: rtl/hsx_pkg.sv
`timescale 1ns/1ps
package hsx_pkg;

  typedef enum logic [1:0] {
    HSX_IDLE     = 2'd0,
    HSX_WAIT_ACK = 2'd1,
    HSX_WAIT_CLR = 2'd2
  } hsx_state_t;

  // Event seen on the synchronized request: a level change (toggle mode)
  // or a rising edge (return-to-zero mode).
  function automatic logic hsx_req_event(input logic two_phase,
                                         input logic cur, input logic prev);
    return two_phase ? (cur ^ prev) : (cur & ~prev);
  endfunction

  // Request level driven when a word is launched.
  function automatic logic hsx_send_level(input logic two_phase, input logic req);
    return two_phase ? ~req : 1'b1;
  endfunction

  // Acknowledge level driven when a word is captured.
  function automatic logic hsx_ack_level(input logic two_phase, input logic ack);
    return two_phase ? ~ack : 1'b1;
  endfunction

  // Source view: has the acknowledge answered the outstanding request?
  function automatic logic hsx_answered(input logic two_phase,
                                        input logic req, input logic ack);
    return two_phase ? (ack == req) : ack;
  endfunction

endpackage

// File: rtl/hsx_sync.sv
`timescale 1ns/1ps
module hsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], d};
  end

  assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/hsx_src.sv
`timescale 1ns/1ps
module hsx_src
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit TWO_PHASE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              req_o,
  output logic [DATA_W-1:0] hold_o,
  input  logic              ack_i
);
  hsx_state_t        st_q;
  logic              req_q;
  logic [DATA_W-1:0] hold_q;
  logic              ack_s;
  logic              accept;
  logic              answered;

  hsx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_i), .q(ack_s)
  );

  assign in_ready = (st_q == HSX_IDLE);
  assign accept   = in_valid && in_ready;
  assign answered = hsx_answered(TWO_PHASE, req_q, ack_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HSX_IDLE;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      case (st_q)
        HSX_IDLE: if (accept) begin
          hold_q <= in_data;
          req_q  <= hsx_send_level(TWO_PHASE, req_q);
          st_q   <= HSX_WAIT_ACK;
        end
        HSX_WAIT_ACK: if (answered) begin
          if (TWO_PHASE) begin
            st_q <= HSX_IDLE;
          end else begin
            req_q <= 1'b0;
            st_q  <= HSX_WAIT_CLR;
          end
        end
        HSX_WAIT_CLR: if (!ack_s) st_q <= HSX_IDLE;
        default: st_q <= HSX_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;

  // R3: an accepted word makes the source busy on the next cycle
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R5: the held word does not move while a handshake is open
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(hold_q));

  if (!TWO_PHASE) begin : g_rz
    // R6: request falls only after the acknowledge has been seen high
    a_r6_req_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(ack_s));
    // R6: ready returns only once the acknowledge is seen low again
    a_r6_ready_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> !$past(ack_s));
  end else begin : g_tg
    // R7: each request level change stems from one acceptance
    a_r7_one_toggle_per_word: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_q) |-> $past(accept));
  end
endmodule

// File: rtl/hsx_dst.sv
`timescale 1ns/1ps
module hsx_dst
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit TWO_PHASE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              ack_o,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              req_s;
  logic              req_d;
  logic              req_evt;
  logic              pend_q;
  logic              vld_q;
  logic              ack_q;
  logic [DATA_W-1:0] dout_q;

  hsx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_i), .q(req_s)
  );

  assign req_evt = hsx_req_event(TWO_PHASE, req_s, req_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      ack_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      req_d  <= req_s;
      pend_q <= req_evt;
      vld_q  <= pend_q;
      if (pend_q) begin
        dout_q <= hold_i;
        ack_q  <= hsx_ack_level(TWO_PHASE, ack_q);
      end else if (!TWO_PHASE && ack_q && !req_s) begin
        ack_q  <= 1'b0;
      end
    end
  end

  assign ack_o     = ack_q;
  assign out_valid = vld_q;
  assign out_data  = dout_q;

  // R4: strobe lasts one cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R4: output word only moves together with the strobe
  a_r4_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(dout_q));

  // R8: capture comes two cycles after the synchronized event
  a_r8_capture_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(req_evt, 2));

  if (!TWO_PHASE) begin : g_rz
    // R6: acknowledge drops only after the request was seen low
    a_r6_ack_fall_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_q) |-> !$past(req_s));
  end
endmodule

// File: rtl/hs_bus_xfer.sv
`timescale 1ns/1ps
module hs_bus_xfer #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit TWO_PHASE   = 1'b0
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_line;
  logic              ack_line;
  logic [DATA_W-1:0] hold_bus;

  hsx_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TWO_PHASE(TWO_PHASE)) u_src (
    .clk(src_clk), .rst_n(src_rst_n),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .req_o(req_line), .hold_o(hold_bus), .ack_i(ack_line)
  );

  hsx_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TWO_PHASE(TWO_PHASE)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n),
    .req_i(req_line), .hold_i(hold_bus), .ack_o(ack_line),
    .out_valid(dst_valid), .out_data(dst_data)
  );

  // R1: source is ready once out of reset and before any acceptance
  a_r1_ready_after_reset: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_rst_n) |-> src_ready);
endmodule

// File: tb/hs_bus_xfer_test.sv
`timescale 1ns/1ps
module hs_bus_xfer_test;
  localparam int DW   = 16;
  localparam int S_RZ = 2;
  localparam int S_TG = 3;
  localparam real TD  = 7.0;

  logic sclk = 1'b0, dclk = 1'b0;
  logic srst_n = 1'b0, drst_n = 1'b0;
  always #2.5 sclk = ~sclk;
  initial begin #1.3; forever #3.5 dclk = ~dclk; end

  logic [1:0]    s_valid = '0;
  logic [1:0]    s_ready;
  logic [1:0]    d_valid;
  logic [DW-1:0] s_data [2];
  logic [DW-1:0] d_data [2];

  hs_bus_xfer #(.DATA_W(DW), .SYNC_STAGES(S_RZ), .TWO_PHASE(1'b0)) uut (
    .src_clk(sclk), .src_rst_n(srst_n), .src_valid(s_valid[0]), .src_ready(s_ready[0]),
    .src_data(s_data[0]), .dst_clk(dclk), .dst_rst_n(drst_n),
    .dst_valid(d_valid[0]), .dst_data(d_data[0]));

  hs_bus_xfer #(.DATA_W(DW), .SYNC_STAGES(S_TG), .TWO_PHASE(1'b1)) uut_tp (
    .src_clk(sclk), .src_rst_n(srst_n), .src_valid(s_valid[1]), .src_ready(s_ready[1]),
    .src_data(s_data[1]), .dst_clk(dclk), .dst_rst_n(drst_n),
    .dst_valid(d_valid[1]), .dst_data(d_data[1]));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] expq [2][0:63];
  real           acct [2][0:63];
  int wr [2] = '{0, 0};
  int rd [2] = '{0, 0};
  int busy_tot [2] = '{0, 0};
  logic prev_v [2] = '{1'b0, 1'b0};
  logic [DW-1:0] last_d [2] = '{16'h0, 16'h0};
  bit done = 1'b0;

  function automatic int stages_of(input int m);
    return (m == 0) ? S_RZ : S_TG;
  endfunction

  // lower bound on latency in ps: (stages + 1) destination periods
  function automatic longint min_lat_ps(input int m);
    return longint'((stages_of(m) + 1) * TD * 1000.0);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // destination monitor, sampled mid-cycle
  always @(negedge dclk) begin
    if (drst_n && !done) begin
      for (int m = 0; m < 2; m++) begin
        if (d_valid[m]) begin
          if (rd[m] < wr[m]) begin
            chk(d_data[m] == expq[m][rd[m]], "R2", "delivered word",
                longint'(d_data[m]), longint'(expq[m][rd[m]]));
            begin
              longint lat;
              lat = longint'((($realtime - 3.5) - acct[m][rd[m]]) * 1000.0);
              chk(lat > min_lat_ps(m), "R8", "latency ps", lat, min_lat_ps(m));
            end
            rd[m]++;
          end else begin
            chk(1'b0, "R3", "extra delivery count", longint'(rd[m] + 1), longint'(wr[m]));
          end
          chk(!prev_v[m], "R4", "valid twice in a row", 1, 0);
          last_d[m] = d_data[m];
        end else begin
          chk(d_data[m] == last_d[m], "R4", "data moved without valid",
              longint'(d_data[m]), longint'(last_d[m]));
        end
        prev_v[m] = d_valid[m];
      end
    end
  end

  task automatic send(input int m, input logic [DW-1:0] d, input bit noisy);
    int busy;
    while (!s_ready[m]) @(negedge sclk);
    s_valid[m] = 1'b1;
    s_data[m]  = d;
    expq[m][wr[m]] = d;
    acct[m][wr[m]] = $realtime + 2.5;
    wr[m]++;
    @(negedge sclk);
    chk(s_ready[m] == 1'b0, "R3", "ready after accept", longint'(s_ready[m]), 0);
    busy = 1;
    s_valid[m] = noisy ? 1'($urandom) : 1'b0;
    if (noisy) s_data[m] = DW'($urandom);
    forever begin
      @(negedge sclk);
      if (s_ready[m]) begin
        s_valid[m] = 1'b0;
        break;
      end
      busy++;
      if (noisy) begin
        s_valid[m] = 1'($urandom);
        s_data[m]  = DW'($urandom);
      end
    end
    if (m == 0)
      chk(busy >= 4 * S_RZ, "R6", "busy cycles per word", longint'(busy), longint'(4 * S_RZ));
    busy_tot[m] += busy;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sclk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    s_data[0] = '0;
    s_data[1] = '0;
    repeat (4) @(negedge sclk);
    srst_n = 1'b1;
    @(negedge dclk);
    drst_n = 1'b1;
    repeat (2) @(negedge sclk);
    chk(s_ready == 2'b11, "R1", "ready after reset", longint'(s_ready), 3);
    chk(d_valid == 2'b00, "R1", "valid after reset", longint'(d_valid), 0);
    chk(d_data[0] == '0 && d_data[1] == '0, "R1", "data after reset",
        longint'(d_data[0]), 0);

    for (int m = 0; m < 2; m++) begin
      // directed corners, clean bus during handshake
      send(m, 16'h0000, 1'b0);
      send(m, 16'hFFFF, 1'b0);
      send(m, 16'hAAAA, 1'b1);
      send(m, 16'h5555, 1'b1);
      // random words with valid/data noise while busy (R3, R5)
      for (int k = 0; k < 20; k++) send(m, DW'($urandom), 1'b1);
    end

    repeat (60) @(negedge sclk);
    for (int m = 0; m < 2; m++)
      chk(rd[m] == wr[m], (m == 0) ? "R2" : "R7", "words delivered",
          longint'(rd[m]), longint'(wr[m]));
    chk((wr[1] % 2) == 0 && rd[1] >= 2, "R7", "toggle words both levels",
        longint'(rd[1]), longint'(wr[1]));
    chk(busy_tot[1] < busy_tot[0], "R7", "toggle busy below return-to-zero",
        longint'(busy_tot[1]), longint'(busy_tot[0]));
    chk(s_ready == 2'b11, "R3", "ready at end", longint'(s_ready), 3);
    done = 1'b1;
    summary();
  end
endmodule